// File: doc/BRIEF.md
# Packed SIMD Arithmetic-Logic Unit

This block is a 64-bit packed-integer ALU for a vector datapath. Each cycle it can accept a destination operand A, a source operand B, a four-bit operation code and a two-bit lane-size select. One clock later it presents the 64-bit result in a pipeline register, together with a valid strobe. The 64-bit word is treated as eight 8-bit lanes, four 16-bit lanes, two 32-bit lanes or one 64-bit lane, and each lane is computed on its own.

The block covers lane-wise addition and subtraction in three flavours: wraparound, signed clamping and unsigned clamping. It also has equality and signed greater-than compares that produce lane masks, four bitwise operations, and logical and arithmetic shifts by a scalar count taken from B. Some combinations of operation and lane size are not allowed. For those, the block passes A through unchanged and raises an error flag for that single output cycle.

There is no state machine. The only state is one pipeline stage, and it has two conditions. Idle means `res_valid` is low. Loaded means `res_valid` is high and the result is held. On every clock edge where `in_valid` is high the stage becomes Loaded. On every edge where `in_valid` is low it returns to Idle.

Top module: `simd_alu`

## Requirements
- R1: After reset, `res_valid`, `op_error` and `result` are all zero. `res_valid` on any clock edge equals the `in_valid` seen at the previous edge. When `in_valid` is low, `result` holds its previous value.
- R2: Opcode codes are 0 add, 3 subtract (A minus B), 6 equal, 7 greater, 8 and, 9 and-not, 10 or, 11 xor, 12 shift left, 13 shift right logical, 14 shift right arithmetic, and 1, 2, 4, 5 for the clamped forms listed in R3 and R4. Lane codes are 0 for 8-bit, 1 for 16-bit, 2 for 32-bit and 3 for 64-bit. Wraparound add (0) and subtract (3) work at all four lane sizes, and no carry crosses a lane boundary.
- R3: Signed clamped add (1) and subtract (4) are legal only at 8- and 16-bit lanes. A lane result that would pass the signed maximum becomes the maximum, and one that would pass the signed minimum becomes the minimum.
- R4: Unsigned clamped add (2) and subtract (5) are legal only at 8- and 16-bit lanes. Add clamps at the all-ones lane value and subtract clamps at zero.
- R5: Equal (6) and signed greater-than, A greater than B (7), are legal at 8-, 16- and 32-bit lanes. Each result lane is all ones when the condition holds and all zeros otherwise.
- R6: The bitwise operations are and (8), and-not (9), or (10) and xor (11). And-not computes (NOT A) AND B. These four ignore the lane-size select and are legal at every lane size.
- R7: Shifts use the whole 64-bit B as the count. Left shift (12) and logical right shift (13) are legal at 16, 32 and 64 bits. Arithmetic right shift (14) is legal at 16 and 32 bits. A count equal to or above the lane width clears the lane for logical shifts and fills it with the sign bit for the arithmetic shift.
- R8: Opcode 15, and any combination not named as legal in R2 to R7, makes `result` equal A and raises `op_error` in the same cycle as `res_valid`. `op_error` is low on every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and codes below are valid this cycle |
| opnd_a | input | 64 | Destination operand A |
| opnd_b | input | 64 | Source operand B, or shift count |
| opcode | input | 4 | Operation code (see R2) |
| lane_sel | input | 2 | Lane size: 0=8, 1=16, 2=32, 3=64 bits |
| res_valid | output | 1 | Result valid, one clock after `in_valid` |
| result | output | 64 | Registered packed result |
| op_error | output | 1 | Illegal opcode and lane combination on this result |

## Verification
An illegal-combination report and a legal result can land in consecutive output cycles. The error flag must then be bound to its own request and must not leak into its neighbour. The bench provokes this by issuing a 32-bit clamped add directly before and after legal operations, with no idle cycle between them. Because every cycle's expectation is computed from that cycle's own inputs, any smear of the error flag or of the passed-through A fails a check. Random traffic with back-to-back issue and occasional idle gaps also exercises the valid pipeline against the operation results in the same cycles.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD   = 4'd0,
        OP_ADDSS = 4'd1,
        OP_ADDUS = 4'd2,
        OP_SUB   = 4'd3,
        OP_SUBSS = 4'd4,
        OP_SUBUS = 4'd5,
        OP_CMPEQ = 4'd6,
        OP_CMPGT = 4'd7,
        OP_AND   = 4'd8,
        OP_ANDN  = 4'd9,
        OP_OR    = 4'd10,
        OP_XOR   = 4'd11,
        OP_SHL   = 4'd12,
        OP_SHR   = 4'd13,
        OP_SAR   = 4'd14,
        OP_RSVD  = 4'd15
    } alu_op_e;

    typedef enum logic [1:0] {
        LS_8  = 2'd0,
        LS_16 = 2'd1,
        LS_32 = 2'd2,
        LS_64 = 2'd3
    } lane_sz_e;

endpackage

// File: rtl/simd_op_legal.sv
module simd_op_legal
    import simd_alu_pkg::*;
(
    input  alu_op_e  op,
    input  lane_sz_e sz,
    output logic     legal
);

    always_comb begin
        legal = 1'b0;
        unique case (op)
            OP_ADD, OP_SUB:                        legal = 1'b1;
            OP_ADDSS, OP_ADDUS, OP_SUBSS, OP_SUBUS: legal = (sz == LS_8) || (sz == LS_16);
            OP_CMPEQ, OP_CMPGT:                    legal = (sz != LS_64);
            OP_AND, OP_ANDN, OP_OR, OP_XOR:        legal = 1'b1;
            OP_SHL, OP_SHR:                        legal = (sz != LS_8);
            OP_SAR:                                legal = (sz == LS_16) || (sz == LS_32);
            OP_RSVD:                               legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/simd_lane_unit.sv
module simd_lane_unit
    import simd_alu_pkg::*;
#(
    parameter int DW = 64,
    parameter int LW = 8
)(
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  alu_op_e       op,
    output logic [DW-1:0] res
);

    localparam int LANES = DW / LW;
    localparam int CW    = $clog2(LW);

    // shift count at or above the lane width
    logic          cnt_big;
    logic [CW-1:0] cnt;

    assign cnt_big = |b[DW-1:CW];
    assign cnt     = b[CW-1:0];

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [LW-1:0] la, lb, lr;
        logic [LW:0]   usum, udif, ssum, sdif;
        logic [LW-1:0] smax, smin;

        assign la   = a[k*LW +: LW];
        assign lb   = b[k*LW +: LW];
        assign usum = {1'b0, la} + {1'b0, lb};
        assign udif = {1'b0, la} - {1'b0, lb};
        assign ssum = {la[LW-1], la} + {lb[LW-1], lb};
        assign sdif = {la[LW-1], la} - {lb[LW-1], lb};
        assign smax = {1'b0, {(LW-1){1'b1}}};
        assign smin = {1'b1, {(LW-1){1'b0}}};

        always_comb begin
            case (op)
                OP_ADD:   lr = usum[LW-1:0];
                OP_SUB:   lr = udif[LW-1:0];
                OP_ADDSS: lr = (ssum[LW] != ssum[LW-1]) ? (ssum[LW] ? smin : smax) : ssum[LW-1:0];
                OP_SUBSS: lr = (sdif[LW] != sdif[LW-1]) ? (sdif[LW] ? smin : smax) : sdif[LW-1:0];
                OP_ADDUS: lr = usum[LW] ? {LW{1'b1}} : usum[LW-1:0];
                OP_SUBUS: lr = udif[LW] ? {LW{1'b0}} : udif[LW-1:0];
                OP_CMPEQ: lr = {LW{la == lb}};
                OP_CMPGT: lr = {LW{$signed(la) > $signed(lb)}};
                OP_SHL:   lr = cnt_big ? {LW{1'b0}} : (la << cnt);
                OP_SHR:   lr = cnt_big ? {LW{1'b0}} : (la >> cnt);
                OP_SAR:   lr = cnt_big ? {LW{la[LW-1]}} : LW'($signed(la) >>> cnt);
                default:  lr = la;
            endcase
        end

        assign res[k*LW +: LW] = lr;
    end

endmodule

// File: rtl/simd_alu.sv
module simd_alu
    import simd_alu_pkg::*;
#(
    parameter int DW = 64
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] opnd_a,
    input  logic [DW-1:0] opnd_b,
    input  logic [3:0]    opcode,
    input  logic [1:0]    lane_sel,
    output logic          res_valid,
    output logic [DW-1:0] result,
    output logic          op_error
);

    localparam int NSZ = 4;

    alu_op_e       op;
    lane_sz_e      sz;
    logic          legal;
    logic [DW-1:0] unit_res [NSZ];
    logic [DW-1:0] arith_res, logic_res, next_res;
    logic          is_logic;

    assign op = alu_op_e'(opcode);
    assign sz = lane_sz_e'(lane_sel);

    simd_op_legal u_legal (
        .op    (op),
        .sz    (sz),
        .legal (legal)
    );

    for (genvar g = 0; g < NSZ; g++) begin : g_size
        simd_lane_unit #(.DW(DW), .LW(8 << g)) u_unit (
            .a   (opnd_a),
            .b   (opnd_b),
            .op  (op),
            .res (unit_res[g])
        );
    end

    always_comb begin
        is_logic  = 1'b1;
        logic_res = '0;
        unique case (op)
            OP_AND:  logic_res = opnd_a & opnd_b;
            OP_ANDN: logic_res = ~opnd_a & opnd_b;
            OP_OR:   logic_res = opnd_a | opnd_b;
            OP_XOR:  logic_res = opnd_a ^ opnd_b;
            default: is_logic  = 1'b0;
        endcase
    end

    assign arith_res = unit_res[lane_sel];

    always_comb begin
        if (!legal)        next_res = opnd_a;
        else if (is_logic) next_res = logic_res;
        else               next_res = arith_res;
    end

    // pipeline stage register: Idle when res_valid low, Loaded when high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            op_error  <= 1'b0;
            result    <= '0;
        end else begin
            res_valid <= in_valid;
            op_error  <= in_valid && !legal;
            if (in_valid) result <= next_res;
        end
    end

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> res_valid);
    // R1
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!res_valid && $stable(result)));
    // R8
    error_only_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_error |-> res_valid);
    // R8
    rsvd_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == 4'd15) |=> (op_error && result == $past(opnd_a)));
    // R5
    mask_bytes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && legal && (op == OP_CMPEQ || op == OP_CMPGT)) |=>
        (result[7:0]   inside {8'h00, 8'hFF} && result[15:8]  inside {8'h00, 8'hFF} &&
         result[23:16] inside {8'h00, 8'hFF} && result[31:24] inside {8'h00, 8'hFF} &&
         result[39:32] inside {8'h00, 8'hFF} && result[47:40] inside {8'h00, 8'hFF} &&
         result[55:48] inside {8'h00, 8'hFF} && result[63:56] inside {8'h00, 8'hFF}));
    // R4
    sat_sub_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == 4'd5 && lane_sel == 2'd0 && opnd_a == '0) |=> (result == '0));

endmodule

// File: tb/simd_alu_tb.sv
module simd_alu_tb_top;

    localparam real CLK_NS = 20.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] opnd_a = '0, opnd_b = '0;
    logic [3:0]  opcode = '0;
    logic [1:0]  lane_sel = '0;
    logic        res_valid, op_error;
    logic [63:0] result;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    bit          pend_v = 0;
    logic [63:0] pend_res = '0;
    bit          pend_err = 0;
    string       pend_tag = "R1";

    always #(CLK_NS/2) clk = ~clk;

    simd_alu dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .opcode(opcode), .lane_sel(lane_sel),
        .res_valid(res_valid), .result(result), .op_error(op_error)
    );

    function automatic bit is_legal(logic [3:0] op, logic [1:0] ls);
        case (op)
            4'd0, 4'd3, 4'd8, 4'd9, 4'd10, 4'd11: return 1;
            4'd1, 4'd2, 4'd4, 4'd5: return ls <= 2'd1;
            4'd6, 4'd7:   return ls != 2'd3;
            4'd12, 4'd13: return ls != 2'd0;
            4'd14:        return ls == 2'd1 || ls == 2'd2;
            default:      return 0;
        endcase
    endfunction

    function automatic string tag_of(logic [3:0] op, logic [1:0] ls);
        if (!is_legal(op, ls)) return "R8";
        case (op)
            4'd0, 4'd3: return "R2";
            4'd1, 4'd4: return "R3";
            4'd2, 4'd5: return "R4";
            4'd6, 4'd7: return "R5";
            4'd8, 4'd9, 4'd10, 4'd11: return "R6";
            default: return "R7";
        endcase
    endfunction

    function automatic logic [63:0] ref_res(logic [63:0] a, logic [63:0] b,
                                            logic [3:0] op, logic [1:0] ls);
        logic [63:0] acc;
        int w, n;
        if (!is_legal(op, ls)) return a;
        case (op)
            4'd8:  return a & b;
            4'd9:  return ~a & b;
            4'd10: return a | b;
            4'd11: return a ^ b;
            default: ;
        endcase
        w = 8 << ls;
        if (w == 64) begin
            case (op)
                4'd0:  return a + b;
                4'd3:  return a - b;
                4'd12: return (b >= 64) ? 64'd0 : a << b[5:0];
                default: return (b >= 64) ? 64'd0 : a >> b[5:0];
            endcase
        end
        n = 64 / w;
        acc = '0;
        for (int k = 0; k < n; k++) begin
            longint ua, ub, sa, sb, r, m, half;
            m    = (longint'(1) << w) - 1;
            half = longint'(1) << (w - 1);
            ua = longint'((a >> (k*w)) & 64'(m));
            ub = longint'((b >> (k*w)) & 64'(m));
            sa = (ua >= half) ? ua - (longint'(1) << w) : ua;
            sb = (ub >= half) ? ub - (longint'(1) << w) : ub;
            case (op)
                4'd0: r = ua + ub;
                4'd3: r = ua - ub;
                4'd1: begin r = sa + sb; if (r > half-1) r = half-1; if (r < -half) r = -half; end
                4'd4: begin r = sa - sb; if (r > half-1) r = half-1; if (r < -half) r = -half; end
                4'd2: begin r = ua + ub; if (r > m) r = m; end
                4'd5: begin r = ua - ub; if (r < 0) r = 0; end
                4'd6: r = (ua == ub) ? -1 : 0;
                4'd7: r = (sa > sb) ? -1 : 0;
                4'd12: r = (b >= 64'(w)) ? 0 : ua << b;
                4'd13: r = (b >= 64'(w)) ? 0 : ua >> b;
                default: r = (b >= 64'(w)) ? ((sa < 0) ? -1 : 0) : sa >>> b;
            endcase
            acc = acc | ((64'(r) & 64'(m)) << (k*w));
        end
        return acc;
    endfunction

    task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic check_prev();
        check(res_valid == pend_v, "R1", "res_valid", 64'(res_valid), 64'(pend_v));
        if (pend_v) begin
            check(result == pend_res, pend_tag, "result", result, pend_res);
            check(op_error == pend_err, "R8", "op_error", 64'(op_error), 64'(pend_err));
        end else begin
            check(op_error == 1'b0, "R8", "op_error idle", 64'(op_error), 64'd0);
            check(result == pend_res, "R1", "result hold", result, pend_res);
        end
    endtask

    task automatic step(logic [63:0] a, logic [63:0] b, logic [3:0] op, logic [1:0] ls, bit v);
        @(negedge clk);
        check_prev();
        in_valid = v; opnd_a = a; opnd_b = b; opcode = op; lane_sel = ls;
        pend_v = v;
        if (v) begin
            pend_res = ref_res(a, b, op, ls);
            pend_err = !is_legal(op, ls);
            pend_tag = tag_of(op, ls);
        end
    endtask

    initial begin
        #(CLK_NS * 200000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'hC0FFEE));
        repeat (3) @(negedge clk);
        // R1 reset state
        check(res_valid == 0 && op_error == 0 && result == 0, "R1", "reset",
              {result[61:0], res_valid, op_error}, 64'd0);
        rst_n = 1'b1;
        // R2 lane isolation and full width carry
        step(64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, 4'd0, 2'd0, 1);
        step(64'h0000_0000_FFFF_FFFF, 64'h1, 4'd0, 2'd3, 1);
        step(64'h0, 64'h1, 4'd3, 2'd1, 1);
        // R3 signed clamps
        step(64'h7F80_7F80_0000_0000, 64'h0180_FF01_0000_0000, 4'd1, 2'd0, 1);
        step(64'h8000_7FFF_0000_0005, 64'h0001_FFFF_0000_0003, 4'd4, 2'd1, 1);
        // R4 unsigned clamps
        step(64'hFFFF_0000_FF00_1234, 64'h0001_0001_0100_0001, 4'd2, 2'd0, 1);
        step(64'h0000_0005_0000_0010, 64'h0001_0006_FFFF_0001, 4'd5, 2'd1, 1);
        // R8 illegal between legal requests, back to back
        step(64'hDEAD_BEEF_0123_4567, 64'h1111, 4'd2, 2'd2, 1);
        step(64'h5, 64'h6, 4'd0, 2'd2, 1);
        step(64'hAAAA, 64'h1, 4'd14, 2'd0, 1);
        step(64'h1234, 64'h1, 4'd15, 2'd1, 1);
        step(64'h1, 64'h1, 4'd6, 2'd3, 1);
        // R5 compares, signed negative lanes
        step(64'h8000_0001_0000_0005, 64'h0000_0001_FFFF_FFFF, 4'd7, 2'd2, 1);
        step(64'h1122_3344_5566_7788, 64'h1122_0044_5500_7788, 4'd6, 2'd0, 1);
        // R6 and-not direction, lane select ignored
        step(64'hF0F0_F0F0_F0F0_F0F0, 64'hFF00_FF00_FF00_FF00, 4'd9, 2'd3, 1);
        step(64'hF0F0_F0F0_F0F0_F0F0, 64'hFF00_FF00_FF00_FF00, 4'd9, 2'd0, 1);
        // R7 shift counts at and around the lane width, and a huge count
        step(64'h8001_8001_8001_8001, 64'd15, 4'd14, 2'd1, 1);
        step(64'h8001_8001_8001_8001, 64'd16, 4'd14, 2'd1, 1);
        step(64'h8000_0000_7FFF_FFFF, 64'h1_0000_0000, 4'd14, 2'd2, 1);
        step(64'hFFFF_FFFF_FFFF_FFFF, 64'd63, 4'd12, 2'd3, 1);
        step(64'hFFFF_FFFF_FFFF_FFFF, 64'd64, 4'd13, 2'd3, 1);
        step(64'h1234_5678_9ABC_DEF0, 64'd32, 4'd12, 2'd2, 1);
        step(64'h0, 64'h0, 4'd0, 2'd0, 0);
        step(64'h0, 64'h0, 4'd0, 2'd0, 0);
        // random traffic
        for (int i = 0; i < 3000; i++) begin
            logic [63:0] a, b;
            logic [3:0]  op;
            logic [1:0]  ls;
            a  = {$urandom, $urandom};
            b  = {$urandom, $urandom};
            op = 4'($urandom % 16);
            ls = 2'($urandom % 4);
            if (op >= 4'd12 && ($urandom % 4) != 0) b = 64'($urandom % 70);
            if (($urandom % 8) == 0) b = a;
            step(a, b, op, ls, ($urandom % 6) != 0);
        end
        step(64'h0, 64'h0, 4'd0, 2'd0, 0);
        step(64'h0, 64'h0, 4'd0, 2'd0, 0);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule